// File: doc/BRIEF.md
# Oscilloscope Trigger Unit

This block decides the moment a capture should start. It watches a stream of samples, each marked by a one-cycle valid strobe, and raises a single-cycle trigger pulse when the configured condition is met. The condition is either a threshold crossing of a 10-bit analog sample, or a masked match on an 8-bit logic sample. A crossing can optionally be qualified by the width of the pulse it starts: the pulse must be narrower than a limit, or at least as wide as that limit. Software writes a packed control byte, a low threshold byte, a width limit, two holdoff bytes, and a pattern and mask pair. It then pulses `arm_i` to start a search.

The control byte packs several fields. Bit 7 enables triggering. Bits [6:5] pick the mode. Bits [4:3] pick what drives the trigger-out pin. Bit 2 picks the falling edge. Bits [1:0] give the top of the threshold. The trigger-out pin carries either the trigger pulse or one of two externally generated waveforms (a PWM level and a noise level), which arrive as inputs.

A state machine sequences the search. The states are `ST_IDLE`, `ST_HOLD`, `ST_SEEK`, `ST_MEAS` and `ST_DONE`.
- Reset leaves the machine in `ST_IDLE`.
- `arm_i` from any state goes to `ST_HOLD`, or to `ST_SEEK` when the holdoff is zero.
- In `ST_HOLD`, the last holdoff strobe moves the machine to `ST_SEEK`.
- In `ST_SEEK`, a qualifying edge in a width mode moves to `ST_MEAS`.
- In `ST_MEAS`, an opposite crossing that fails the width test returns to `ST_SEEK`. Clearing the enable bit also returns to `ST_SEEK`.
- A firing condition in `ST_SEEK` or `ST_MEAS` moves to `ST_DONE`, where the machine stays until the next arm.

Top module: `scope_trigger_unit`

## Requirements
- R1: After reset no trigger pulse is produced, whatever the samples, until `arm_i` has been pulsed.
- R2: The holdoff is the 16-bit value {`hold_hi_i`,`hold_lo_i`}. The first that-many sample strobes after an arm can never fire a trigger, but they do update the stored previous sample. The next strobe can fire.
- R3: While control bit 7 is 0, no trigger pulse is produced.
- R4: Mode 00 (bits [6:5]) with bit 2 clear fires when the previous strobed sample is below the threshold {bits[1:0],`thr_lo_i`} and the current one is at or above it. `trig_pulse_o` is high for exactly the one cycle after the clock edge that samples that strobe.
- R5: With bit 2 set, the qualifying edge is falling: the previous sample is at or above the threshold and the current one is below it.
- R6: The first strobed sample after an arm has no predecessor and can never complete a crossing.
- R7: Mode 01 fires at the opposite crossing that ends a pulse when the pulse width is below `width_lim_i`. The width is the number of strobes from the qualifying-edge sample to the opposite-crossing sample. A failing pulse resumes the search.
- R8: Mode 10 fires at the opposite crossing when the width is at or above `width_lim_i`. Otherwise it resumes the search without firing.
- R9: Mode 11 fires on a strobe where every logic channel whose mask bit is 0 equals its pattern bit. Channels whose mask bit is 1 are ignored.
- R10: After a trigger has fired, no further pulse occurs until the next arm.
- R11: `trig_out_o` follows control bits [4:3]: 00 gives the trigger pulse, 01 gives `pwm_i`, 11 gives `noise_i`, and 10 gives 0.
- R12: The trigger condition is only evaluated on cycles where `smp_vld_i` is high. A sample presented without the strobe is neither compared nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle request to start a new trigger search |
| cfg_i | input | 8 | Packed control byte (enable, mode, out source, slope, threshold top) |
| thr_lo_i | input | 8 | Lower threshold bits |
| width_lim_i | input | 8 | Pulse width limit in sample periods |
| hold_lo_i | input | 8 | Holdoff count, low byte |
| hold_hi_i | input | 8 | Holdoff count, high byte |
| pat_i | input | 8 | Logic pattern value |
| mask_i | input | 8 | Logic mask (1 = channel ignored) |
| smp_vld_i | input | 1 | Sample-valid strobe |
| ana_i | input | 10 | Analog sample |
| la_i | input | 8 | Logic sample |
| pwm_i | input | 1 | Externally generated PWM level |
| noise_i | input | 1 | Externally generated noise level |
| trig_pulse_o | output | 1 | One-cycle trigger pulse |
| trig_out_o | output | 1 | External trigger-out signal |

## Verification
The bench builds the block with its default parameters: 10-bit analog samples, 8-bit logic samples, a 16-bit holdoff and an 8-bit width limit. At these widths the threshold boundary at 384 can be hit exactly from both sides. The bench also sets a holdoff of 258, so the high holdoff byte matters and the first strobe after the holdoff window can be placed precisely. A width limit of 3 puts widths 1, 2 and 3 on both sides of the narrow and wide comparisons.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SEEK,
        ST_MEAS,
        ST_DONE
    } trig_state_t;

    typedef enum logic [1:0] {
        MODE_LEVEL   = 2'b00,
        MODE_NARROW  = 2'b01,
        MODE_WIDE    = 2'b10,
        MODE_PATTERN = 2'b11
    } trig_mode_t;

    typedef enum logic [1:0] {
        SRC_PULSE = 2'b00,
        SRC_PWM   = 2'b01,
        SRC_NONE  = 2'b10,
        SRC_NOISE = 2'b11
    } trig_src_t;

    localparam int CFG_EN_BIT    = 7;
    localparam int CFG_MODE_HI   = 6;
    localparam int CFG_MODE_LO   = 5;
    localparam int CFG_SRC_HI    = 4;
    localparam int CFG_SRC_LO    = 3;
    localparam int CFG_SLOPE_BIT = 2;
    localparam int CFG_THR_HI    = 1;

endpackage

// File: rtl/trig_cross_det.sv
module trig_cross_det #(
    parameter int SMP_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] thr_i,
    output logic             rise_o,
    output logic             fall_o
);

    logic [SMP_W-1:0] prev_q;
    logic             have_q;
    logic             prev_below;
    logic             now_at_or_above;
    logic             usable;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (clr_i) begin
            have_q <= 1'b0;
        end else if (vld_i) begin
            prev_q <= smp_i;
            have_q <= 1'b1;
        end
    end

    assign prev_below      = prev_q < thr_i;
    assign now_at_or_above = smp_i >= thr_i;
    assign usable          = vld_i && have_q && !clr_i;
    assign rise_o          = usable && prev_below && now_at_or_above;
    assign fall_o          = usable && !prev_below && !now_at_or_above;

    // R6: a crossing needs a stored sample from an earlier strobe
    p_cross_needs_history_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(have_q) |-> !$past(rise_o || fall_o));

endmodule

// File: rtl/trig_pattern_cmp.sv
module trig_pattern_cmp #(
    parameter int LA_W = 8
) (
    input  logic [LA_W-1:0] la_i,
    input  logic [LA_W-1:0] pat_i,
    input  logic [LA_W-1:0] mask_i,
    output logic            match_o
);

    logic [LA_W-1:0] diff;

    for (genvar g = 0; g < LA_W; g++) begin : g_chan
        assign diff[g] = (la_i[g] ^ pat_i[g]) & ~mask_i[g];
    end

    assign match_o = ~|diff;

endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
    import trig_pkg::*;
(
    input  trig_src_t sel_i,
    input  logic      pulse_i,
    input  logic      pwm_i,
    input  logic      noise_i,
    output logic      out_o
);

    always_comb begin
        unique case (sel_i)
            SRC_PULSE: out_o = pulse_i;
            SRC_PWM:   out_o = pwm_i;
            SRC_NOISE: out_o = noise_i;
            default:   out_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/scope_trigger_unit.sv
module scope_trigger_unit
    import trig_pkg::*;
#(
    parameter int SMP_W  = 10,
    parameter int LA_W   = 8,
    parameter int HOLD_W = 16,
    parameter int WID_W  = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                arm_i,
    input  logic [7:0]          cfg_i,
    input  logic [SMP_W-3:0]    thr_lo_i,
    input  logic [WID_W-1:0]    width_lim_i,
    input  logic [HOLD_W/2-1:0] hold_lo_i,
    input  logic [HOLD_W/2-1:0] hold_hi_i,
    input  logic [LA_W-1:0]     pat_i,
    input  logic [LA_W-1:0]     mask_i,
    input  logic                smp_vld_i,
    input  logic [SMP_W-1:0]    ana_i,
    input  logic [LA_W-1:0]     la_i,
    input  logic                pwm_i,
    input  logic                noise_i,
    output logic                trig_pulse_o,
    output logic                trig_out_o
);

    localparam int CNT_W = WID_W + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(1) << WID_W;

    trig_state_t       state_q, state_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    logic [CNT_W-1:0]  wid_q, wid_d;
    logic [CNT_W-1:0]  wid_step;
    logic              fire;
    logic              pulse_q;

    logic              en;
    logic              falling;
    trig_mode_t        mode;
    trig_src_t         src;
    logic [SMP_W-1:0]  thr;
    logic [HOLD_W-1:0] hold_total;
    logic              rise, fall, qual, opp;
    logic              match;
    logic              width_ok;

    assign en         = cfg_i[CFG_EN_BIT];
    assign falling    = cfg_i[CFG_SLOPE_BIT];
    assign mode       = trig_mode_t'(cfg_i[CFG_MODE_HI:CFG_MODE_LO]);
    assign src        = trig_src_t'(cfg_i[CFG_SRC_HI:CFG_SRC_LO]);
    assign thr        = {cfg_i[CFG_THR_HI:0], thr_lo_i};
    assign hold_total = {hold_hi_i, hold_lo_i};

    trig_cross_det #(.SMP_W(SMP_W)) u_cross (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (arm_i),
        .vld_i  (smp_vld_i),
        .smp_i  (ana_i),
        .thr_i  (thr),
        .rise_o (rise),
        .fall_o (fall)
    );

    trig_pattern_cmp #(.LA_W(LA_W)) u_pat (
        .la_i    (la_i),
        .pat_i   (pat_i),
        .mask_i  (mask_i),
        .match_o (match)
    );

    trig_out_sel u_out (
        .sel_i   (src),
        .pulse_i (pulse_q),
        .pwm_i   (pwm_i),
        .noise_i (noise_i),
        .out_o   (trig_out_o)
    );

    assign qual     = falling ? fall : rise;
    assign opp      = falling ? rise : fall;
    assign wid_step = (wid_q == CNT_SAT) ? wid_q : wid_q + CNT_W'(1);
    assign width_ok = (mode == MODE_NARROW) ? (wid_step <  {1'b0, width_lim_i})
                                            : (wid_step >= {1'b0, width_lim_i});

    // next-state and fire decision
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        wid_d   = wid_q;
        fire    = 1'b0;
        if (arm_i) begin
            hold_d  = hold_total;
            wid_d   = '0;
            state_d = (hold_total == '0) ? ST_SEEK : ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_HOLD: begin
                    if (smp_vld_i) begin
                        hold_d = hold_q - HOLD_W'(1);
                        if (hold_q == HOLD_W'(1)) state_d = ST_SEEK;
                    end
                end
                ST_SEEK: begin
                    if (smp_vld_i && en) begin
                        unique case (mode)
                            MODE_LEVEL:   fire = qual;
                            MODE_PATTERN: fire = match;
                            default: begin
                                if (qual) begin
                                    wid_d   = '0;
                                    state_d = ST_MEAS;
                                end
                            end
                        endcase
                    end
                end
                ST_MEAS: begin
                    if (!en || mode == MODE_LEVEL || mode == MODE_PATTERN) begin
                        state_d = ST_SEEK;
                    end else if (smp_vld_i) begin
                        wid_d = wid_step;
                        if (opp) begin
                            if (width_ok) fire = 1'b1;
                            else          state_d = ST_SEEK;
                        end
                    end
                end
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
            if (fire) state_d = ST_DONE;
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            wid_q   <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            wid_q   <= wid_d;
        end
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pulse_q <= 1'b0;
        else         pulse_q <= fire;
    end

    assign trig_pulse_o = pulse_q;

    // R4: a pulse lasts one cycle
    p_one_cycle_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |=> !pulse_q);

    // R3: a pulse implies the enable bit was set on the deciding cycle
    p_enable_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |-> $past(cfg_i[CFG_EN_BIT]));

    // R12: a pulse implies a strobe on the deciding cycle
    p_strobe_paced_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_q |-> $past(smp_vld_i));

    // R2: arming always restarts the search
    p_arm_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> (state_q == ST_HOLD || state_q == ST_SEEK));

    // R10: once fired the machine stays silent until re-armed
    p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DONE && !arm_i) |=> (state_q == ST_DONE && !pulse_q));

    // R1: without an arm the idle state is never left
    p_idle_waits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !arm_i) |=> state_q == ST_IDLE);

endmodule

// File: tb/tb_scope_trigger_unit.sv
`timescale 1ns/1ps
module tb_scope_trigger_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       arm;
    logic [7:0] cfg, thr_lo, wlim, hlo, hhi, pat, mask, la;
    logic       vld, pwm, noise;
    logic [9:0] ana;
    logic       pulse, tout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    scope_trigger_unit dut (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .cfg_i(cfg),
        .thr_lo_i(thr_lo), .width_lim_i(wlim), .hold_lo_i(hlo), .hold_hi_i(hhi),
        .pat_i(pat), .mask_i(mask), .smp_vld_i(vld), .ana_i(ana), .la_i(la),
        .pwm_i(pwm), .noise_i(noise), .trig_pulse_o(pulse), .trig_out_o(tout)
    );

    typedef struct packed {
        logic [7:0] cfg;
        logic       arm;
        logic       vld;
        logic [9:0] ana;
        logic [7:0] la;
        logic [7:0] pat;
        logic [7:0] mask;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // threshold = {2'b01, 8'h80} = 384, width limit 3, holdoff 0
    localparam int NV = 53;
    localparam vec_t VT [NV] = '{
        // R1: not armed yet
        '{8'h81,1'b0,1'b1,10'd500,8'h00,8'h00,8'hFF,1'b0,4'd1},
        '{8'h81,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd1},
        '{8'h81,1'b0,1'b1,10'd500,8'h00,8'h00,8'hFF,1'b0,4'd1},
        // R4 rising level, then R10 single shot
        '{8'h81,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd4},
        '{8'h81,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd6},
        '{8'h81,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b1,4'd4},
        '{8'h81,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd10},
        '{8'h81,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd10},
        // R6 no predecessor, R4 equal-to-threshold boundary
        '{8'h81,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd6},
        '{8'h81,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd6},
        '{8'h81,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd4},
        '{8'h81,1'b0,1'b1,10'd383,8'h00,8'h00,8'hFF,1'b0,4'd4},
        '{8'h81,1'b0,1'b1,10'd384,8'h00,8'h00,8'hFF,1'b1,4'd4},
        // R5 falling edge
        '{8'h85,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd5},
        '{8'h85,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd5},
        '{8'h85,1'b0,1'b1,10'd384,8'h00,8'h00,8'hFF,1'b0,4'd5},
        '{8'h85,1'b0,1'b1,10'd383,8'h00,8'h00,8'hFF,1'b1,4'd5},
        // R3 disabled
        '{8'h01,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd3},
        '{8'h01,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd3},
        '{8'h01,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd3},
        // R12 sample without strobe ignored
        '{8'h81,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd12},
        '{8'h81,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd12},
        '{8'h81,1'b0,1'b0,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd12},
        '{8'h81,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b1,4'd12},
        // R7 narrow: width 2 fires
        '{8'hA1,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b1,4'd7},
        // R7 narrow: width 3 rejected, then width 1 fires
        '{8'hA1,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd7},
        '{8'hA1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b1,4'd7},
        // R8 wide: width 1 rejected, width 3 fires
        '{8'hC1,1'b1,1'b0,10'd0,  8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd400,8'h00,8'h00,8'hFF,1'b0,4'd8},
        '{8'hC1,1'b0,1'b1,10'd100,8'h00,8'h00,8'hFF,1'b1,4'd8},
        // R9 pattern: upper nibble compared
        '{8'hE1,1'b1,1'b0,10'd0,  8'h00,8'h50,8'h0F,1'b0,4'd9},
        '{8'hE1,1'b0,1'b1,10'd0,  8'h4A,8'h50,8'h0F,1'b0,4'd9},
        '{8'hE1,1'b0,1'b1,10'd0,  8'h5F,8'h50,8'h0F,1'b1,4'd9},
        // R9 pattern: all channels compared
        '{8'hE1,1'b1,1'b0,10'd0,  8'h00,8'hA5,8'h00,1'b0,4'd9},
        '{8'hE1,1'b0,1'b1,10'd0,  8'hA4,8'hA5,8'h00,1'b0,4'd9},
        '{8'hE1,1'b0,1'b1,10'd0,  8'hA5,8'hA5,8'h00,1'b1,4'd9},
        // R9 pattern: all channels ignored
        '{8'hE1,1'b1,1'b0,10'd0,  8'h00,8'hA5,8'hFF,1'b0,4'd9},
        '{8'hE1,1'b0,1'b1,10'd0,  8'h00,8'hA5,8'hFF,1'b1,4'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; arm = 1'b0; cfg = 8'h81; thr_lo = 8'h80; wlim = 8'd3;
        hlo = 8'h00; hhi = 8'h00; pat = 8'h00; mask = 8'hFF; la = 8'h00;
        vld = 1'b0; ana = '0; pwm = 1'b0; noise = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 reset pulse", 32'(pulse), 32'd0);
        check("R11 reset trig_out", 32'(tout), 32'd0);

        // vector table; trig_out source 00 follows the pulse (R11)
        for (int i = 0; i < NV; i++) begin
            cfg = VT[i].cfg; arm = VT[i].arm; vld = VT[i].vld;
            ana = VT[i].ana; la = VT[i].la; pat = VT[i].pat; mask = VT[i].mask;
            @(negedge clk);
            check($sformatf("R%0d vector %0d pulse", VT[i].req, i), 32'(pulse), 32'(VT[i].exp));
            check($sformatf("R11 vector %0d trig_out", i), 32'(tout), 32'(VT[i].exp));
        end
        arm = 1'b0; vld = 1'b0;

        // R2: holdoff of 258 strobes, crossings inside are ignored
        begin
            int seen;
            seen = 0;
            cfg = 8'h81; hhi = 8'h01; hlo = 8'h02; arm = 1'b1;
            @(negedge clk);
            arm = 1'b0;
            for (int k = 1; k <= 258; k++) begin
                vld = 1'b1;
                ana = (k % 2 == 1) ? 10'd400 : 10'd100;
                @(negedge clk);
                if (pulse) seen++;
            end
            check("R2 no pulse during holdoff", 32'(seen), 32'd0);
            ana = 10'd400;
            @(negedge clk);
            check("R2 first strobe after holdoff fires", 32'(pulse), 32'd1);
            vld = 1'b0; hhi = 8'h00; hlo = 8'h00;
        end

        // R11: trig_out source select
        cfg = 8'h09; pwm = 1'b1; noise = 1'b0; #1;
        check("R11 pwm high", 32'(tout), 32'd1);
        pwm = 1'b0; #1;
        check("R11 pwm low", 32'(tout), 32'd0);
        cfg = 8'h19; noise = 1'b1; #1;
        check("R11 noise high", 32'(tout), 32'd1);
        cfg = 8'h11; pwm = 1'b1; #1;
        check("R11 select 10 gives low", 32'(tout), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule